// File: doc/BRIEF.md
# Exception Cause Selection and Vectoring Unit

This unit sits at the completion point of a processor pipeline. Each cycle it receives the class flags of the completing instruction, the translation and cache-attribute results for that instruction, the low bits of its effective address and its access size, and the current machine-state bits. It decides whether an exception must be taken. When one is taken, it raises a single take pulse together with the vector offset, a cause code and, for program exceptions, a one-hot subtype field. Software saves that subtype field in its status-save register.

The unit also contains a down-counting decrementer. The counter steps on a timebase enable and can be loaded through a write port. A 0-to-1 change of its most significant bit raises an asynchronous request. That request waits while external interrupts are disabled and is serviced at the lowest priority. Instruction decode, address translation, state save and vector fetch all stay outside the unit and only reach it as flags.

Top module: `trap_select`

## Requirements
- R1: While reset is asserted and on the first cycle after it, take_o, cause_o, vec_o, psub_o and dec_value are all zero, and no decrementer request is pending.
- R2: The outputs are registered. The inputs present at a rising clock edge decide take_o, cause_o, vec_o and psub_o during the following cycle. The cause codes and vector offsets are: alignment 1 / 0x00600, program 2 / 0x00700, floating-point unavailable 3 / 0x00800, decrementer 4 / 0x00900, system call 5 / 0x00C00, trace 6 / 0x00D00, instruction translation miss 7 / 0x01000, data load translation miss 8 / 0x01100, data store translation miss 9 / 0x01200. No other offset is ever produced.
- R3: An alignment exception is raised in five cases. (a) A floating-point load or store has ea_lo[1:0] not zero. (b) A load/store-multiple or reservation access has ea_lo[1:0] not zero. (c) A single-register access with msr_le=1 has ea_lo not a multiple of 2^acc_size, where acc_size 0, 1, 2, 3 means 1, 2, 4, 8 bytes. (d) A multiple or string instruction completes with msr_le=1. (e) A cache-block-zero targets a region with attr_wt=1 or attr_ci=1.
- R4: A completing floating-point instruction with (msr_fe0 OR msr_fe1) AND fpscr_fex raises a program exception with psub_o = 4'b0001.
- R5: With msr_pr=1, a privileged instruction raises a program exception with psub_o = 4'b0100. A register move with an invalid register field and spr_hi=1 does the same. With msr_pr=0, neither case raises anything.
- R6: An illegal or unimplemented instruction raises a program exception with psub_o = 4'b0010. A trap whose condition holds raises one with psub_o = 4'b1000.
- R7: Any floating-point instruction, including floating-point loads and stores, raises floating-point unavailable when msr_fp=0.
- R8: A system-call instruction raises system call. Trace is raised when msr_se=1, or when the completing instruction is a branch and msr_be=1.
- R9: imiss raises an instruction translation miss. dmiss on a load raises a data load miss. dmiss on a store raises a data store miss.
- R10: The decrementer loads dec_wdata on dec_wr and otherwise decrements by one, modulo 2^DEC_W, on tb_tick. A write takes precedence over a tick.
- R11: A 0-to-1 change of the decrementer MSB, whether from a load or a step, sets a pending request. The request is taken only while msr_ee=1, and cmp_valid does not need to be 1. It stays pending until it is taken. A new rise on the same edge keeps it pending.
- R12: When several causes are active, the priority is: instruction miss, data load miss, data store miss, alignment, program, floating-point unavailable, system call, trace, decrementer. Among the program subtypes the priority is: illegal, privileged, floating-point enabled, trap. psub_o is zero for every cause other than program.
- R13: The synchronous causes are considered only when cmp_valid=1. When nothing is taken, cause_o, vec_o and psub_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | An instruction is completing this cycle |
| cls_fp | input | 1 | Completing instruction is floating-point (any kind) |
| cls_fp_mem | input | 1 | Floating-point load or store |
| cls_single_mem | input | 1 | Single-register load or store |
| cls_multi | input | 1 | Load/store multiple |
| cls_resv | input | 1 | Reservation load or conditional store |
| cls_string | input | 1 | String load or store |
| cls_cbz | input | 1 | Cache-block-zero operation |
| cls_branch | input | 1 | Branch instruction |
| cls_sc | input | 1 | System-call instruction |
| cls_priv | input | 1 | Privileged instruction |
| cls_spr_move | input | 1 | Move to or from a special register |
| spr_bad | input | 1 | Special-register field is invalid |
| spr_hi | input | 1 | High-order bit of the special-register field |
| cls_illegal | input | 1 | Illegal or unimplemented instruction |
| trap_hit | input | 1 | Trap instruction condition holds |
| acc_load | input | 1 | Access is a load |
| acc_store | input | 1 | Access is a store |
| ea_lo | input | 3 | Low bits of the effective address |
| acc_size | input | 2 | log2 of access size in bytes |
| attr_wt | input | 1 | Target region is write-through |
| attr_ci | input | 1 | Target region is caching-inhibited |
| imiss | input | 1 | Instruction fetch translation miss |
| dmiss | input | 1 | Data translation miss |
| msr_pr | input | 1 | User privilege state |
| msr_fp | input | 1 | Floating-point available |
| msr_fe0 | input | 1 | Floating-point exception mode bit 0 |
| msr_fe1 | input | 1 | Floating-point exception mode bit 1 |
| msr_ee | input | 1 | External / decrementer interrupt enable |
| msr_se | input | 1 | Single-step trace enable |
| msr_be | input | 1 | Branch trace enable |
| msr_le | input | 1 | Little-endian mode |
| fpscr_fex | input | 1 | Enabled floating-point exception summary |
| tb_tick | input | 1 | Timebase step enable for the decrementer |
| dec_wr | input | 1 | Load the decrementer |
| dec_wdata | input | DEC_W | Decrementer load value |
| dec_value | output | DEC_W | Current decrementer value |
| take_o | output | 1 | Exception taken this cycle |
| vec_o | output | VEC_W | Vector offset of the taken exception |
| cause_o | output | 4 | Cause code of the taken exception |
| psub_o | output | 4 | One-hot program subtype (bit0 FP enabled, bit1 illegal, bit2 privileged, bit3 trap) |

## Verification
The bench builds the unit with DEC_W=8 and keeps VEC_W at its default of 20. With the narrow counter, a wrap from zero and a load-driven MSB rise take only a handful of ticks, so pending, deferral under msr_ee=0 and late servicing occur many times during the mixed random phase. VEC_W=20 holds every offset, including 0x01200, without truncation.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [3:0] {
    EXC_NONE   = 4'd0,
    EXC_ALIGN  = 4'd1,
    EXC_PROG   = 4'd2,
    EXC_FPU    = 4'd3,
    EXC_DEC    = 4'd4,
    EXC_SC     = 4'd5,
    EXC_TRACE  = 4'd6,
    EXC_IMISS  = 4'd7,
    EXC_DLMISS = 4'd8,
    EXC_DSMISS = 4'd9
  } exc_e;

  // synchronous cause requests, already qualified by a completing instruction
  typedef struct packed {
    logic imiss;
    logic dlmiss;
    logic dsmiss;
    logic align;
    logic prog;
    logic fpu;
    logic sc;
    logic trace;
  } sync_req_t;

  // program subtype bit positions
  localparam int PSUB_FPEN  = 0;
  localparam int PSUB_ILL   = 1;
  localparam int PSUB_PRIV  = 2;
  localparam int PSUB_TRAP  = 3;

  function automatic logic [31:0] trap_vec_of(input exc_e c);
    logic [31:0] v;
    case (c)
      EXC_ALIGN:  v = 32'h0000_0600;
      EXC_PROG:   v = 32'h0000_0700;
      EXC_FPU:    v = 32'h0000_0800;
      EXC_DEC:    v = 32'h0000_0900;
      EXC_SC:     v = 32'h0000_0C00;
      EXC_TRACE:  v = 32'h0000_0D00;
      EXC_IMISS:  v = 32'h0000_1000;
      EXC_DLMISS: v = 32'h0000_1100;
      EXC_DSMISS: v = 32'h0000_1200;
      default:    v = 32'h0000_0000;
    endcase
    return v;
  endfunction

  // true when the address low bits are not a multiple of the access size
  function automatic logic trap_misaligned(input logic [2:0] ea, input logic [1:0] sz);
    logic bad;
    case (sz)
      2'd0:    bad = 1'b0;
      2'd1:    bad = ea[0];
      2'd2:    bad = |ea[1:0];
      default: bad = |ea[2:0];
    endcase
    return bad;
  endfunction

  // keep only the highest-priority subtype: illegal, privileged, fp enabled, trap
  function automatic logic [3:0] trap_pick_sub(input logic [3:0] raw);
    logic [3:0] s;
    s = 4'b0000;
    if (raw[PSUB_ILL])       s[PSUB_ILL]  = 1'b1;
    else if (raw[PSUB_PRIV]) s[PSUB_PRIV] = 1'b1;
    else if (raw[PSUB_FPEN]) s[PSUB_FPEN] = 1'b1;
    else if (raw[PSUB_TRAP]) s[PSUB_TRAP] = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/trap_dec_timer.sv
module trap_dec_timer
  import trap_pkg::*;
#(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [DEC_W-1:0] wdata,
  input  logic             grant,
  output logic [DEC_W-1:0] value,
  output logic             pend,
  output logic             msb_rise
);

  localparam int MSB = DEC_W - 1;

  logic [DEC_W-1:0] cnt_q;
  logic [DEC_W-1:0] cnt_next;
  logic             pend_q;

  always_comb begin
    if (wr)
      cnt_next = wdata;
    else if (tick)
      cnt_next = cnt_q - DEC_W'(1);
    else
      cnt_next = cnt_q;
  end

  assign msb_rise = cnt_next[MSB] & ~cnt_q[MSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      if (msb_rise)
        pend_q <= 1'b1;
      else if (grant)
        pend_q <= 1'b0;
    end
  end

  assign value = cnt_q;
  assign pend  = pend_q;

  assert_dec_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (value == $past(wdata)));

  assert_dec_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr) |=> (value == $past(value) - DEC_W'(1)));

  assert_dec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(value));

  assert_dec_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(value[MSB]) |-> pend);

  assert_dec_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !grant) |=> pend);

endmodule

// File: rtl/trap_cause_detect.sv
module trap_cause_detect
  import trap_pkg::*;
(
  input  logic       cmp_valid,
  input  logic       cls_fp,
  input  logic       cls_fp_mem,
  input  logic       cls_single_mem,
  input  logic       cls_multi,
  input  logic       cls_resv,
  input  logic       cls_string,
  input  logic       cls_cbz,
  input  logic       cls_branch,
  input  logic       cls_sc,
  input  logic       cls_priv,
  input  logic       cls_spr_move,
  input  logic       spr_bad,
  input  logic       spr_hi,
  input  logic       cls_illegal,
  input  logic       trap_hit,
  input  logic       acc_load,
  input  logic       acc_store,
  input  logic [2:0] ea_lo,
  input  logic [1:0] acc_size,
  input  logic       attr_wt,
  input  logic       attr_ci,
  input  logic       imiss,
  input  logic       dmiss,
  input  logic       msr_pr,
  input  logic       msr_fp,
  input  logic       msr_fe0,
  input  logic       msr_fe1,
  input  logic       msr_se,
  input  logic       msr_be,
  input  logic       msr_le,
  input  logic       fpscr_fex,
  output sync_req_t  req,
  output logic [3:0] psub_raw
);

  // named alignment events
  logic word_off;
  logic al_fpmem;
  logic al_word_ops;
  logic al_le_single;
  logic al_le_multi;
  logic al_cbz;
  logic align_any;

  // named program events
  logic pg_fpen;
  logic pg_ill;
  logic pg_priv;
  logic pg_trap;

  assign word_off     = |ea_lo[1:0];
  assign al_fpmem     = cls_fp_mem & word_off;
  assign al_word_ops  = (cls_multi | cls_resv) & word_off;
  assign al_le_single = cls_single_mem & msr_le & trap_misaligned(ea_lo, acc_size);
  assign al_le_multi  = (cls_multi | cls_string) & msr_le;
  assign al_cbz       = cls_cbz & (attr_wt | attr_ci);
  assign align_any    = al_fpmem | al_word_ops | al_le_single | al_le_multi | al_cbz;

  assign pg_fpen = cls_fp & (msr_fe0 | msr_fe1) & fpscr_fex;
  assign pg_ill  = cls_illegal;
  assign pg_priv = msr_pr & (cls_priv | (cls_spr_move & spr_bad & spr_hi));
  assign pg_trap = trap_hit;

  always_comb begin
    psub_raw            = 4'b0000;
    psub_raw[PSUB_FPEN] = pg_fpen;
    psub_raw[PSUB_ILL]  = pg_ill;
    psub_raw[PSUB_PRIV] = pg_priv;
    psub_raw[PSUB_TRAP] = pg_trap;
  end

  always_comb begin
    req.imiss  = cmp_valid & imiss;
    req.dlmiss = cmp_valid & dmiss & acc_load;
    req.dsmiss = cmp_valid & dmiss & acc_store;
    req.align  = cmp_valid & align_any;
    req.prog   = cmp_valid & (|psub_raw);
    req.fpu    = cmp_valid & cls_fp & ~msr_fp;
    req.sc     = cmp_valid & cls_sc;
    req.trace  = cmp_valid & (msr_se | (cls_branch & msr_be));
  end

  always_comb begin
    assert_valid_gate_R13: assert (cmp_valid || (req == '0));
  end

endmodule

// File: rtl/trap_prio_enc.sv
module trap_prio_enc
  import trap_pkg::*;
#(
  parameter int VEC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sync_req_t        req,
  input  logic [3:0]       psub_raw,
  input  logic             dec_req,
  output logic             dec_grant,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [3:0]       cause_o,
  output logic [3:0]       psub_o
);

  exc_e        sel;
  logic [31:0] sel_vec;
  logic [3:0]  sel_sub;

  logic             take_q;
  logic [VEC_W-1:0] vec_q;
  exc_e             cause_q;
  logic [3:0]       psub_q;

  always_comb begin
    sel = EXC_NONE;
    if (req.imiss)       sel = EXC_IMISS;
    else if (req.dlmiss) sel = EXC_DLMISS;
    else if (req.dsmiss) sel = EXC_DSMISS;
    else if (req.align)  sel = EXC_ALIGN;
    else if (req.prog)   sel = EXC_PROG;
    else if (req.fpu)    sel = EXC_FPU;
    else if (req.sc)     sel = EXC_SC;
    else if (req.trace)  sel = EXC_TRACE;
    else if (dec_req)    sel = EXC_DEC;
  end

  assign sel_vec   = trap_vec_of(sel);
  assign sel_sub   = (sel == EXC_PROG) ? trap_pick_sub(psub_raw) : 4'b0000;
  assign dec_grant = (sel == EXC_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      vec_q   <= '0;
      cause_q <= EXC_NONE;
      psub_q  <= 4'b0000;
    end else begin
      take_q  <= (sel != EXC_NONE);
      vec_q   <= sel_vec[VEC_W-1:0];
      cause_q <= sel;
      psub_q  <= sel_sub;
    end
  end

  assign take_o  = take_q;
  assign vec_o   = vec_q;
  assign cause_o = cause_q;
  assign psub_o  = psub_q;

  assert_vec_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_o inside {VEC_W'(32'h600), VEC_W'(32'h700), VEC_W'(32'h800),
                              VEC_W'(32'h900), VEC_W'(32'hC00), VEC_W'(32'hD00),
                              VEC_W'(32'h1000), VEC_W'(32'h1100), VEC_W'(32'h1200)}));

  assert_idle_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == 4'd0 && vec_o == '0 && psub_o == 4'b0000));

  assert_sub_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == 4'd2) |-> ($countones(psub_o) == 1));

  assert_sub_other_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o != 4'd2) |-> (psub_o == 4'b0000));

  assert_dec_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cause_o == 4'd4) |-> ($past(req) == '0));

  assert_dec_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cause_o == 4'd4) |-> $past(dec_req));

endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int DEC_W = 32,
  parameter int VEC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             cls_fp,
  input  logic             cls_fp_mem,
  input  logic             cls_single_mem,
  input  logic             cls_multi,
  input  logic             cls_resv,
  input  logic             cls_string,
  input  logic             cls_cbz,
  input  logic             cls_branch,
  input  logic             cls_sc,
  input  logic             cls_priv,
  input  logic             cls_spr_move,
  input  logic             spr_bad,
  input  logic             spr_hi,
  input  logic             cls_illegal,
  input  logic             trap_hit,
  input  logic             acc_load,
  input  logic             acc_store,
  input  logic [2:0]       ea_lo,
  input  logic [1:0]       acc_size,
  input  logic             attr_wt,
  input  logic             attr_ci,
  input  logic             imiss,
  input  logic             dmiss,
  input  logic             msr_pr,
  input  logic             msr_fp,
  input  logic             msr_fe0,
  input  logic             msr_fe1,
  input  logic             msr_ee,
  input  logic             msr_se,
  input  logic             msr_be,
  input  logic             msr_le,
  input  logic             fpscr_fex,
  input  logic             tb_tick,
  input  logic             dec_wr,
  input  logic [DEC_W-1:0] dec_wdata,
  output logic [DEC_W-1:0] dec_value,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [3:0]       cause_o,
  output logic [3:0]       psub_o
);

  sync_req_t  req;
  logic [3:0] psub_raw;
  logic       dec_pend;
  logic       dec_rise;
  logic       dec_req;
  logic       dec_grant;

  trap_cause_detect u_detect (
    .cmp_valid      (cmp_valid),
    .cls_fp         (cls_fp),
    .cls_fp_mem     (cls_fp_mem),
    .cls_single_mem (cls_single_mem),
    .cls_multi      (cls_multi),
    .cls_resv       (cls_resv),
    .cls_string     (cls_string),
    .cls_cbz        (cls_cbz),
    .cls_branch     (cls_branch),
    .cls_sc         (cls_sc),
    .cls_priv       (cls_priv),
    .cls_spr_move   (cls_spr_move),
    .spr_bad        (spr_bad),
    .spr_hi         (spr_hi),
    .cls_illegal    (cls_illegal),
    .trap_hit       (trap_hit),
    .acc_load       (acc_load),
    .acc_store      (acc_store),
    .ea_lo          (ea_lo),
    .acc_size       (acc_size),
    .attr_wt        (attr_wt),
    .attr_ci        (attr_ci),
    .imiss          (imiss),
    .dmiss          (dmiss),
    .msr_pr         (msr_pr),
    .msr_fp         (msr_fp),
    .msr_fe0        (msr_fe0),
    .msr_fe1        (msr_fe1),
    .msr_se         (msr_se),
    .msr_be         (msr_be),
    .msr_le         (msr_le),
    .fpscr_fex      (fpscr_fex),
    .req            (req),
    .psub_raw       (psub_raw)
  );

  trap_dec_timer #(.DEC_W(DEC_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tb_tick),
    .wr       (dec_wr),
    .wdata    (dec_wdata),
    .grant    (dec_grant),
    .value    (dec_value),
    .pend     (dec_pend),
    .msb_rise (dec_rise)
  );

  assign dec_req = dec_pend & msr_ee;

  trap_prio_enc #(.VEC_W(VEC_W)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .psub_raw  (psub_raw),
    .dec_req   (dec_req),
    .dec_grant (dec_grant),
    .take_o    (take_o),
    .vec_o     (vec_o),
    .cause_o   (cause_o),
    .psub_o    (psub_o)
  );

  assert_sync_needs_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cause_o != 4'd4) |-> $past(cmp_valid));

  assert_rise_sets_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_rise |=> dec_pend);

  assert_no_dec_when_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_ee && req == '0) |=> !take_o);

endmodule

// File: tb/sim_trap_select.sv
`timescale 1ns/1ps
module sim_trap_select;

  localparam int DW = 8;
  localparam int VW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid, cls_fp, cls_fp_mem, cls_single_mem, cls_multi, cls_resv, cls_string;
  logic cls_cbz, cls_branch, cls_sc, cls_priv, cls_spr_move, spr_bad, spr_hi;
  logic cls_illegal, trap_hit, acc_load, acc_store;
  logic [2:0] ea_lo;
  logic [1:0] acc_size;
  logic attr_wt, attr_ci, imiss, dmiss;
  logic msr_pr, msr_fp, msr_fe0, msr_fe1, msr_ee, msr_se, msr_be, msr_le, fpscr_fex;
  logic tb_tick, dec_wr;
  logic [DW-1:0] dec_wdata;
  logic [DW-1:0] dec_value;
  logic take_o;
  logic [VW-1:0] vec_o;
  logic [3:0] cause_o;
  logic [3:0] psub_o;

  trap_select #(.DEC_W(DW), .VEC_W(VW)) u0 (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit finished = 0;

  // reference model state
  logic [DW-1:0] m_dec = '0;
  bit            m_pend = 0;
  bit            e_take = 0;
  int            e_cause = 0;
  int            e_vec = 0;
  int            e_sub = 0;

  // candidate order: imiss, dload, dstore, align, prog, fpu, sc, trace, dec
  int code_tab[9] = '{7, 8, 9, 1, 2, 3, 5, 6, 4};
  int vec_tab[9]  = '{'h1000, 'h1100, 'h1200, 'h600, 'h700, 'h800, 'hC00, 'hD00, 'h900};
  // subtype bit index in priority order: illegal, privileged, fp enabled, trap
  int sub_order[4] = '{1, 2, 0, 3};

  task automatic clear_in();
    {cmp_valid, cls_fp, cls_fp_mem, cls_single_mem, cls_multi, cls_resv, cls_string} = '0;
    {cls_cbz, cls_branch, cls_sc, cls_priv, cls_spr_move, spr_bad, spr_hi} = '0;
    {cls_illegal, trap_hit, acc_load, acc_store, attr_wt, attr_ci, imiss, dmiss} = '0;
    ea_lo = 3'd0; acc_size = 2'd0;
    {msr_pr, msr_fe0, msr_fe1, msr_ee, msr_se, msr_be, msr_le, fpscr_fex} = '0;
    msr_fp = 1'b1;
    tb_tick = 1'b0; dec_wr = 1'b0; dec_wdata = '0;
  endtask

  task automatic model_next();
    logic [DW-1:0] nd;
    bit rise, misal, al, fpen, pv;
    bit [8:0] act;
    bit [3:0] raw;
    int pick;
    int unit;
    if (dec_wr) nd = dec_wdata;
    else if (tb_tick) nd = m_dec - 1;
    else nd = m_dec;
    rise = nd[DW-1] && !m_dec[DW-1];
    unit = 1 << acc_size;
    misal = (int'(ea_lo) % unit) != 0;
    al = (cls_fp_mem && ea_lo[1:0] != 0)
      || ((cls_multi || cls_resv) && (ea_lo % 4) != 0)
      || (cls_single_mem && msr_le && misal)
      || ((cls_multi || cls_string) && msr_le)
      || (cls_cbz && (attr_wt || attr_ci));
    fpen = cls_fp && fpscr_fex && (msr_fe0 || msr_fe1);
    pv = msr_pr && (cls_priv || (cls_spr_move && spr_bad && spr_hi));
    raw = {trap_hit, pv, cls_illegal, fpen};
    act[0] = imiss;
    act[1] = dmiss && acc_load;
    act[2] = dmiss && acc_store;
    act[3] = al;
    act[4] = raw != 0;
    act[5] = cls_fp && !msr_fp;
    act[6] = cls_sc;
    act[7] = msr_se || (cls_branch && msr_be);
    if (!cmp_valid) act = '0;
    act[8] = m_pend && msr_ee;
    pick = -1;
    for (int i = 0; i < 9; i++) if (act[i] && pick < 0) pick = i;
    e_take = pick >= 0;
    e_cause = (pick >= 0) ? code_tab[pick] : 0;
    e_vec = (pick >= 0) ? vec_tab[pick] : 0;
    e_sub = 0;
    if (pick == 4)
      for (int k = 3; k >= 0; k--) if (raw[sub_order[k]]) e_sub = 1 << sub_order[k];
    if (rise) m_pend = 1;
    else if (pick == 8) m_pend = 0;
    m_dec = nd;
  endtask

  task automatic compare();
    total++;
    if (take_o !== e_take || int'(cause_o) != e_cause || int'(vec_o) != e_vec
        || int'(psub_o) != e_sub || dec_value !== m_dec) begin
      bad++;
      $display("FAIL %s: got take=%0b cause=%0d vec=%h sub=%b dec=%h exp take=%0b cause=%0d vec=%h sub=%b dec=%h",
               tag, take_o, cause_o, vec_o, psub_o, dec_value,
               e_take, e_cause, e_vec, e_sub[3:0], m_dec);
    end
  endtask

  // inputs are set at a falling edge; the model advances, the design takes the
  // rising edge, and the outputs are compared at the next falling edge
  task automatic step();
    model_next();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic one(input string t);
    tag = t;
    step();
    clear_in();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    tag = "R1"; step();

    // R9 / R2 translation misses
    cmp_valid = 1; imiss = 1;                    one("R9");
    cmp_valid = 1; dmiss = 1; acc_load = 1;      one("R9");
    cmp_valid = 1; dmiss = 1; acc_store = 1;     one("R9");
    cmp_valid = 1; dmiss = 1;                    one("R9");

    // R3 alignment cases and their non-faulting counterparts
    cmp_valid = 1; cls_fp_mem = 1; ea_lo = 3'd2;                  one("R3");
    cmp_valid = 1; cls_fp_mem = 1; ea_lo = 3'd4;                  one("R3");
    cmp_valid = 1; cls_resv = 1; ea_lo = 3'd1;                    one("R3");
    cmp_valid = 1; cls_multi = 1; ea_lo = 3'd3;                   one("R3");
    cmp_valid = 1; cls_single_mem = 1; acc_size = 2'd2; ea_lo = 3'd2; msr_le = 1; one("R3");
    cmp_valid = 1; cls_single_mem = 1; acc_size = 2'd2; ea_lo = 3'd2;            one("R3");
    cmp_valid = 1; cls_single_mem = 1; acc_size = 2'd3; ea_lo = 3'd4; msr_le = 1; one("R3");
    cmp_valid = 1; cls_single_mem = 1; acc_size = 2'd1; ea_lo = 3'd6; msr_le = 1; one("R3");
    cmp_valid = 1; cls_string = 1; msr_le = 1;                    one("R3");
    cmp_valid = 1; cls_string = 1;                                one("R3");
    cmp_valid = 1; cls_cbz = 1; attr_ci = 1;                      one("R3");
    cmp_valid = 1; cls_cbz = 1; attr_wt = 1;                      one("R3");
    cmp_valid = 1; cls_cbz = 1;                                   one("R3");

    // R4 floating-point enabled
    cmp_valid = 1; cls_fp = 1; msr_fe1 = 1; fpscr_fex = 1;        one("R4");
    cmp_valid = 1; cls_fp = 1; fpscr_fex = 1;                     one("R4");
    // R5 privileged
    cmp_valid = 1; cls_priv = 1; msr_pr = 1;                      one("R5");
    cmp_valid = 1; cls_priv = 1;                                  one("R5");
    cmp_valid = 1; cls_spr_move = 1; spr_bad = 1; spr_hi = 1; msr_pr = 1; one("R5");
    cmp_valid = 1; cls_spr_move = 1; spr_bad = 1; msr_pr = 1;     one("R5");
    // R6 illegal and trap
    cmp_valid = 1; cls_illegal = 1;                               one("R6");
    cmp_valid = 1; trap_hit = 1;                                  one("R6");
    // R7 floating-point unavailable
    cmp_valid = 1; cls_fp = 1; cls_fp_mem = 1; msr_fp = 0;        one("R7");
    // R8 system call and trace
    cmp_valid = 1; cls_sc = 1;                                    one("R8");
    cmp_valid = 1; msr_se = 1;                                    one("R8");
    cmp_valid = 1; cls_branch = 1; msr_be = 1;                    one("R8");
    cmp_valid = 1; cls_branch = 1;                                one("R8");
    // R13 no completing instruction
    imiss = 1; cls_sc = 1; cls_illegal = 1; msr_se = 1;           one("R13");

    // R12 priorities
    cmp_valid = 1; imiss = 1; cls_multi = 1; msr_le = 1; cls_sc = 1; one("R12");
    cmp_valid = 1; dmiss = 1; acc_store = 1; cls_string = 1; msr_le = 1; one("R12");
    cmp_valid = 1; cls_cbz = 1; attr_ci = 1; cls_illegal = 1;     one("R12");
    cmp_valid = 1; trap_hit = 1; cls_priv = 1; msr_pr = 1; cls_illegal = 1; one("R12");
    cmp_valid = 1; trap_hit = 1; cls_fp = 1; msr_fe0 = 1; fpscr_fex = 1; one("R12");
    cmp_valid = 1; cls_fp = 1; msr_fp = 0; cls_sc = 1;            one("R12");
    cmp_valid = 1; cls_sc = 1; msr_se = 1;                        one("R12");

    // R10 decrementer load and stepping, write beats tick
    dec_wr = 1; dec_wdata = 8'h05;                                one("R10");
    tb_tick = 1;                                                  one("R10");
    tb_tick = 1; dec_wr = 1; dec_wdata = 8'h20;                   one("R10");
    one("R10");

    // R11 wrap from zero with interrupts masked, then enabled
    dec_wr = 1; dec_wdata = 8'h00;                                one("R11");
    tb_tick = 1;                                                  one("R11");
    repeat (3) one("R11");
    msr_ee = 1; cmp_valid = 1; cls_sc = 1;                        one("R11");
    msr_ee = 1;                                                   one("R11");
    msr_ee = 1;                                                   one("R11");
    // load-driven rise, taken with no completing instruction
    dec_wr = 1; dec_wdata = 8'h10;                                one("R11");
    dec_wr = 1; dec_wdata = 8'h90; msr_ee = 1;                    one("R11");
    msr_ee = 1;                                                   one("R11");

    // mixed random traffic
    tag = "R12";
    for (int n = 0; n < 4000; n++) begin
      cmp_valid      = ($urandom % 4) != 0;
      cls_fp         = ($urandom % 8) == 0;
      cls_fp_mem     = ($urandom % 10) == 0;
      cls_single_mem = ($urandom % 4) == 0;
      cls_multi      = ($urandom % 16) == 0;
      cls_resv       = ($urandom % 16) == 0;
      cls_string     = ($urandom % 16) == 0;
      cls_cbz        = ($urandom % 12) == 0;
      cls_branch     = ($urandom % 5) == 0;
      cls_sc         = ($urandom % 16) == 0;
      cls_priv       = ($urandom % 12) == 0;
      cls_spr_move   = ($urandom % 8) == 0;
      spr_bad        = ($urandom % 2) == 0;
      spr_hi         = ($urandom % 2) == 0;
      cls_illegal    = ($urandom % 20) == 0;
      trap_hit       = ($urandom % 20) == 0;
      acc_load       = ($urandom % 3) == 0;
      acc_store      = ($urandom % 3) == 0;
      ea_lo          = 3'($urandom);
      acc_size       = 2'($urandom);
      attr_wt        = ($urandom % 4) == 0;
      attr_ci        = ($urandom % 4) == 0;
      imiss          = ($urandom % 40) == 0;
      dmiss          = ($urandom % 24) == 0;
      msr_pr         = ($urandom % 3) == 0;
      msr_fp         = ($urandom % 6) != 0;
      msr_fe0        = ($urandom % 3) == 0;
      msr_fe1        = ($urandom % 3) == 0;
      msr_ee         = ($urandom % 3) != 0;
      msr_se         = ($urandom % 24) == 0;
      msr_be         = ($urandom % 4) == 0;
      msr_le         = ($urandom % 4) == 0;
      fpscr_fex      = ($urandom % 3) == 0;
      tb_tick        = ($urandom % 2) == 0;
      dec_wr         = ($urandom % 50) == 0;
      dec_wdata      = DW'($urandom);
      step();
    end
    clear_in();
    tag = "R13"; step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule